// File: doc/BRIEF.md
# Bi-quinary decade counter

This block is a four-bit counter split into two sections with separate count inputs. A one-bit divide-by-two section advances on each falling edge of `tick2_i` and drives `dig0_o`. A three-bit divide-by-five section advances on each falling edge of `tick5_i` and drives `dig3_o..dig1_o`. Each section sees only its own input. The sections can be chained outside the block in two ways. Feeding `dig0_o` into `tick5_i` gives a BCD decade count of pulses on `tick2_i`. Feeding `dig3_o` into `tick2_i` gives a square wave at one tenth of the `tick5_i` pulse rate on `dig0_o`.

The count inputs are ordinary data signals and do not act as clocks. Each one passes through a two-flop synchronizer on `clk_i`. A falling edge is recognized when the registered level goes from high to low. Two gated control pairs override counting. When both clear inputs are high, the counter is forced to zero. When both nine inputs are high, the counter is forced to nine, and this takes priority over the clear pair. A force holds for as long as its pair stays high.

Top module: `biq_ctr`

## Requirements
- R1: While `rst_ni` is low, all four outputs are 0, and they remain 0 after release until a count edge or a force occurs.
- R2: Each falling edge of `tick2_i` inverts `dig0_o`. A rising edge of `tick2_i` has no effect on any output.
- R3: The divide-by-five value {`dig3_o`,`dig2_o`,`dig1_o`} (`dig1_o` is the LSB) steps through 0,1,2,3,4 and then back to 0, once per falling edge of `tick5_i`. It never exceeds 4.
- R4: An edge on `tick2_i` never changes `dig3_o..dig1_o`, and an edge on `tick5_i` never changes `dig0_o`.
- R5: When `zero_a_i` and `zero_b_i` are both high and the nine pair is not both high, all outputs are 0 one clock later.
- R6: When `nine_a_i` and `nine_b_i` are both high, the outputs {`dig3_o`,`dig2_o`,`dig1_o`,`dig0_o`} become 1001 one clock later, whatever the clear pair is doing.
- R7: If only one input of a pair is high, that pair has no effect, and counting proceeds normally.
- R8: While a force is held, count edges are discarded. After release, the held value stays until the next recognized falling edge, and counting then continues from it.
- R9: After a count input goes low, the affected output changes on the third rising edge of `clk_i`. It is unchanged after the second.
- R10: With `dig0_o` wired to `tick5_i`, successive pulses on `tick2_i` produce the BCD sequence 0..9 and then wrap to 0.
- R11: With `dig3_o` wired to `tick2_i`, pulses on `tick5_i` make `dig0_o` high for five pulses and then low for five.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples everything |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick2_i | input | 1 | Count input of the divide-by-two section |
| tick5_i | input | 1 | Count input of the divide-by-five section |
| zero_a_i | input | 1 | Clear pair, first input |
| zero_b_i | input | 1 | Clear pair, second input |
| nine_a_i | input | 1 | Nine pair, first input |
| nine_b_i | input | 1 | Nine pair, second input |
| dig0_o | output | 1 | Weight 1, divide-by-two output |
| dig1_o | output | 1 | Weight 2, divide-by-five LSB |
| dig2_o | output | 1 | Weight 4 |
| dig3_o | output | 1 | Weight 8, divide-by-five MSB |

## Verification
A count input that goes low shows up at the outputs on the third rising clock edge: two synchronizer flops and then the state register. The bench drives stimulus on falling clock edges, waits at least four cycles, and samples on a falling edge. One directed case samples after the second and after the third edge to pin this latency down exactly. Forces show up one edge after the pair is complete. Forces are therefore checked three cycles into the hold and again after release. In the chained modes, each pulse half lasts ten cycles, which covers the six-edge ripple from one section into the other.

// File: rtl/biq_pkg.sv
package biq_pkg;
  localparam int unsigned QUIN_W = 3;
  typedef logic [QUIN_W-1:0] quin_t;
  localparam quin_t QUIN_LAST = quin_t'(4);
  localparam quin_t QUIN_NINE = quin_t'(4);  // upper three bits of nine
  localparam int unsigned SYNC_DEPTH = 2;

  function automatic quin_t quin_next(quin_t v);
    return (v == QUIN_LAST) ? '0 : v + quin_t'(1);
  endfunction
endpackage

// File: rtl/biq_fall_det.sv
module biq_fall_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q[STAGES-1];

  assign fall_o = last_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/biq_div2.sv
module biq_div2 (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic clr_i,
  input  logic set_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
    else if (step_i) q_o <= ~q_o;
endmodule

// File: rtl/biq_div5.sv
module biq_div5
  import biq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  step_i,
  input  logic  clr_i,
  input  logic  set_i,
  output quin_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     q_o <= '0;
    else if (set_i)  q_o <= QUIN_NINE;
    else if (clr_i)  q_o <= '0;
    else if (step_i) q_o <= quin_next(q_o);
endmodule

// File: rtl/biq_ctr.sv
module biq_ctr
  import biq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick2_i,
  input  logic tick5_i,
  input  logic zero_a_i,
  input  logic zero_b_i,
  input  logic nine_a_i,
  input  logic nine_b_i,
  output logic dig0_o,
  output logic dig1_o,
  output logic dig2_o,
  output logic dig3_o
);
  logic  fall2, fall5;
  logic  nine_req, zero_req;
  quin_t quin_q;

  assign nine_req = nine_a_i & nine_b_i;
  assign zero_req = zero_a_i & zero_b_i & ~nine_req;

  biq_fall_det #(.STAGES(SYNC_DEPTH)) u_fd2 (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(tick2_i), .fall_o(fall2));
  biq_fall_det #(.STAGES(SYNC_DEPTH)) u_fd5 (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(tick5_i), .fall_o(fall5));

  biq_div2 u_div2 (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(fall2),
    .clr_i(zero_req), .set_i(nine_req), .q_o(dig0_o));
  biq_div5 u_div5 (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(fall5),
    .clr_i(zero_req), .set_i(nine_req), .q_o(quin_q));

  assign {dig3_o, dig2_o, dig1_o} = quin_q;
endmodule

// File: rtl/biq_ctr_chk.sv
module biq_ctr_chk
  import biq_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic zero_a_i,
  input logic zero_b_i,
  input logic nine_a_i,
  input logic nine_b_i,
  input logic dig0_o,
  input logic dig1_o,
  input logic dig2_o,
  input logic dig3_o
);
  quin_t quin;
  assign quin = {dig3_o, dig2_o, dig1_o};

  AST_NINE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nine_a_i && nine_b_i) |=> ({dig3_o, dig2_o, dig1_o, dig0_o} == 4'b1001)); // R6

  AST_ZERO_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_a_i && zero_b_i && !(nine_a_i && nine_b_i))
      |=> ({dig3_o, dig2_o, dig1_o, dig0_o} == 4'b0000)); // R5

  AST_QUIN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quin <= QUIN_LAST); // R3

  AST_QUIN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(zero_a_i && zero_b_i) && !(nine_a_i && nine_b_i))
      |=> (quin == $past(quin)) || (quin == quin_next($past(quin)))); // R3

  AST_RESET_ZERO: assert property (@(posedge clk_i)
    !rst_ni |-> ({dig3_o, dig2_o, dig1_o, dig0_o} == 4'b0000)); // R1
endmodule

bind biq_ctr biq_ctr_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .zero_a_i(zero_a_i), .zero_b_i(zero_b_i),
  .nine_a_i(nine_a_i), .nine_b_i(nine_b_i),
  .dig0_o(dig0_o), .dig1_o(dig1_o), .dig2_o(dig2_o), .dig3_o(dig3_o));

// File: tb/biq_ctr_test.sv
module biq_ctr_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_drv = 1'b0, b_drv = 1'b0;
  logic chain_bcd = 1'b0, chain_sym = 1'b0;
  logic za = 1'b0, zb = 1'b0, na = 1'b0, nb = 1'b0;
  logic d0, d1, d2, d3;
  logic tick2, tick5;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic       m2;
  logic [2:0] m5;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign tick2 = chain_sym ? d3 : a_drv;
  assign tick5 = chain_bcd ? d0 : b_drv;

  biq_ctr uut (
    .clk_i(clk), .rst_ni(rst_n), .tick2_i(tick2), .tick5_i(tick5),
    .zero_a_i(za), .zero_b_i(zb), .nine_a_i(na), .nine_b_i(nb),
    .dig0_o(d0), .dig1_o(d1), .dig2_o(d2), .dig3_o(d3));

  function automatic logic [3:0] pack(logic b2, logic [2:0] b5);
    return {b5, b2};
  endfunction

  function automatic logic [2:0] step5(logic [2:0] v);
    return (v == 3'd4) ? 3'd0 : v + 3'd1;
  endfunction

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic check(string req, logic [3:0] exp);
    n_chk++;
    if ({d3, d2, d1, d0} !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at cycle %0d", req, {d3, d2, d1, d0}, exp, cyc);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_a(int half);
    a_drv = 1'b1; wait_n(half);
    a_drv = 1'b0; wait_n(half);
  endtask

  task automatic pulse_b(int half);
    b_drv = 1'b1; wait_n(half);
    b_drv = 1'b0; wait_n(half);
  endtask

  task automatic clear_all();
    za = 1'b1; zb = 1'b1; wait_n(8);
    za = 1'b0; zb = 1'b0; wait_n(2);
    m2 = 1'b0; m5 = 3'd0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    m2 = 1'b0; m5 = 3'd0;
    wait_n(3);
    check("R1 in reset", 4'b0000);
    rst_n = 1'b1;
    wait_n(3);
    check("R1 after release", 4'b0000);

    // R9 latency and R2 rising edge ignored
    a_drv = 1'b1; wait_n(5);
    check("R2 rising edge ignored", 4'b0000);
    a_drv = 1'b0; wait_n(2);
    check("R9 unchanged after two edges", 4'b0000);
    wait_n(1);
    check("R9 changed on third edge", 4'b0001);
    m2 = 1'b1;
    wait_n(3);

    // R3 full quinary sequence, R4 independence
    for (int i = 1; i <= 6; i++) begin
      pulse_b(4);
      m5 = step5(m5);
      check("R3 quinary step / R4 dig0 untouched", pack(m2, m5));
    end

    // R6 priority over clear
    za = 1'b1; zb = 1'b1; na = 1'b1; nb = 1'b1; wait_n(3);
    check("R6 nine wins over clear", 4'b1001);
    na = 1'b0; wait_n(3);
    check("R5 clear once nine pair breaks", 4'b0000);
    za = 1'b0; zb = 1'b0; nb = 1'b0; wait_n(2);
    m2 = 1'b0; m5 = 3'd0;

    // R8 edges during hold discarded, then resume
    na = 1'b1; nb = 1'b1; wait_n(2);
    pulse_a(4); pulse_b(4);
    check("R8 edges ignored while nine held", 4'b1001);
    na = 1'b0; nb = 1'b0; wait_n(4);
    check("R8 value held after release", 4'b1001);
    m2 = 1'b1; m5 = 3'd4;
    pulse_b(4); m5 = step5(m5);
    check("R8 resume from nine", pack(m2, m5));

    // random mixture
    for (int it = 0; it < 300; it++) begin
      int op;
      op = int'($urandom % 8);
      case (op)
        0, 1: begin pulse_a(4); m2 = ~m2; check("R2 toggle", pack(m2, m5)); end
        2, 3: begin pulse_b(4); m5 = step5(m5); check("R3 step", pack(m2, m5)); end
        4: begin
          za = 1'b1; zb = 1'b1; wait_n(3);
          m2 = 1'b0; m5 = 3'd0;
          check("R5 clear", pack(m2, m5));
          pulse_a(4);
          check("R8 ignored while clear held", pack(m2, m5));
          za = 1'b0; zb = 1'b0; wait_n(2);
        end
        5: begin
          za = 1'($urandom); zb = 1'($urandom);
          na = 1'b1; nb = 1'b1; wait_n(3);
          m2 = 1'b1; m5 = 3'd4;
          check("R6 nine", pack(m2, m5));
          na = 1'b0; nb = 1'b0; za = 1'b0; zb = 1'b0; wait_n(2);
        end
        6: begin
          logic s;
          s = 1'($urandom);
          za = s; zb = ~s; na = ~s; nb = s;
          pulse_a(4); m2 = ~m2;
          pulse_b(4); m5 = step5(m5);
          check("R7 half pair no effect", pack(m2, m5));
          za = 1'b0; zb = 1'b0; na = 1'b0; nb = 1'b0; wait_n(1);
        end
        default: begin
          pulse_a(4); pulse_b(4);
          m2 = ~m2; m5 = step5(m5);
          check("R4 both sections", pack(m2, m5));
        end
      endcase
    end

    // R10 BCD chaining
    clear_all();
    chain_bcd = 1'b1;
    for (int n = 1; n <= 12; n++) begin
      pulse_a(10);
      check("R10 BCD count", 4'(n % 10));
    end
    za = 1'b1; zb = 1'b1; wait_n(10);
    chain_bcd = 1'b0; wait_n(4);
    za = 1'b0; zb = 1'b0; wait_n(2);

    // R11 symmetric divide by ten
    chain_sym = 1'b1;
    for (int n = 1; n <= 20; n++) begin
      pulse_b(10);
      check("R11 symmetric", pack(1'((n / 5) % 2), 3'(n % 5)));
    end
    za = 1'b1; zb = 1'b1; wait_n(10);
    chain_sym = 1'b0; wait_n(4);
    za = 1'b0; zb = 1'b0; wait_n(2);
    check("R5 final clear", 4'b0000);

    finish_run();
  end
endmodule